// File: doc/BRIEF.md
# Replica Store with Shared Overflow Sets

This block keeps spare copies of 64-bit memory words whose home location is known to be unreliable. Each copy is filed under its word address. The address's low bits pick one of a number of primary sets, and each primary set has six ways. The remaining upper address bits are stored as a tag and compared on every access. A primary set that runs out of ways can claim one set from a small shared pool of overflow sets. It records the claim in a per-set link flag and pointer, and the claimed pool set is then reserved for that primary set alone.

A request names an operation, a word address and, for writes, a data word. The store answers with a status and, for a successful lookup, the replica data. A request is never compared against the whole store. It searches the indexed primary set first. It then searches the one overflow set that set is linked to, and only when the primary search misses and a link exists. That second search costs one extra cycle, during which no new request is accepted.

Operations use the code on `cmdOp`: 0 lookup, 1 insert, 2 update, and 3 behaves as a lookup. Responses use the code on `rspStatus`: 0 OK, 1 not found, 2 no room. Address bits [SET_BITS-1:0] give the set index and the bits above give the tag.

Top module: `replica_store`

## Requirements
- R1: After reset the store is empty, `rspValid` is low and `cmdReady` is high, and a lookup of any address answers not found (status 1) with zero data.
- R2: A lookup whose address sits in its primary set answers OK (status 0) with the stored data, with `rspValid` high for exactly one cycle, starting one clock edge after the request is accepted.
- R3: The first six distinct addresses inserted into a primary set are all stored in that set: each insert answers OK after one cycle, and later lookups of those addresses also answer after one cycle.
- R4: Inserting a seventh distinct address into a full, unlinked primary set claims a free overflow set and answers OK after one cycle. A later lookup of that address answers OK with its data after two cycles.
- R5: Each pool entry is claimed by at most one primary set. Once all 16 pool entries are claimed, an insert of a new address into any full, unlinked primary set answers no room (status 2).
- R6: An insert that answers no room changes no stored state: the address stays not found, and every previously stored entry keeps its data and latency.
- R7: Inserting an address that is already stored replaces its data in place and uses no extra way. A set holding five addresses, one of them rewritten several times, still takes a sixth distinct address into the primary set.
- R8: An update of a stored address replaces its data and answers OK. An update of an absent address answers not found, stores nothing, and returns zero data, as does every not-found answer.
- R9: A request that misses in a linked primary set answers after two cycles. A miss in an unlinked set answers after one cycle.
- R10: `cmdReady` is low for exactly the one extra cycle of an overflow search, no response is given during that cycle, and `cmdReady` is high at all other times.
- R11: A linked overflow set holds six entries. Once it is full, an insert of a new address into its primary set answers no room after two cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmdValid | input | 1 | Request present |
| cmdReady | output | 1 | Request accepted when high together with cmdValid |
| cmdOp | input | 2 | 0 lookup, 1 insert, 2 update, 3 lookup |
| cmdAddr | input | ADDR_W | Word address; low SET_BITS bits select the set |
| cmdData | input | DATA_W | Data for insert and update |
| rspValid | output | 1 | One-cycle response strobe |
| rspStatus | output | 2 | 0 OK, 1 not found, 2 no room |
| rspData | output | DATA_W | Replica data for an OK lookup, zero otherwise |

## Verification
The assertions take for granted that requests arrive only through the ready/valid handshake. They also rely on `cmdOp` being stable at the accepting edge, so that the recorded operation of the last accepted request is the one a later no-room or not-found answer belongs to. The stimulus keeps within this by issuing one request at a time: it drives it on a falling edge, holds it across exactly one accepting rising edge, and then waits for the response before the next request. Tags are kept to a small range so a bench-side model of set occupancy, links and pool use can predict every status, data word and latency.

// File: rtl/replica_store_pkg.sv
package replica_store_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_INSERT = 2'd1,
    OP_UPDATE = 2'd2,
    OP_SPARE  = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'd0,
    ST_MISS = 2'd1,
    ST_FULL = 2'd2
  } rspStatus_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic wrPrim;  // write primary set: hit way, else first free way
    logic wrOvf;   // write linked overflow set: hit way, else first free way
    logic claim;   // claim lowest free pool set, write its way 0, link it
  } dpStrobe_t;

endpackage

// File: rtl/rso_datapath.sv
module rso_datapath
  import replica_store_pkg::*;
#(
  parameter int TAG_W  = 11,
  parameter int DATA_W = 64,
  parameter int NSETS  = 32,
  parameter int WAYS   = 6,
  parameter int OSETS  = 16,
  localparam int SET_W = $clog2(NSETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int PTR_W = $clog2(OSETS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SET_W-1:0]  qSet,
  input  logic [TAG_W-1:0]  qTag,
  input  logic [DATA_W-1:0] qData,
  input  logic [PTR_W-1:0]  ovfSel,
  input  dpStrobe_t         stb,
  output logic              primHit,
  output logic              primFull,
  output logic [DATA_W-1:0] primData,
  output logic              linked,
  output logic [PTR_W-1:0]  linkPtr,
  output logic              ovfHit,
  output logic              ovfFull,
  output logic [DATA_W-1:0] ovfData,
  output logic              poolAvail
);

  logic [TAG_W-1:0]  primTag [NSETS][WAYS];
  logic [DATA_W-1:0] primDat [NSETS][WAYS];
  logic [WAYS-1:0]   primVal [NSETS];
  logic [TAG_W-1:0]  ovfTag  [OSETS][WAYS];
  logic [DATA_W-1:0] ovfDat  [OSETS][WAYS];
  logic [WAYS-1:0]   ovfVal  [OSETS];
  logic [NSETS-1:0]  linkBit;
  logic [PTR_W-1:0]  linkPtrArr [NSETS];
  logic [OSETS-1:0]  taken;

  logic [WAYS-1:0]   primMatch, ovfMatch;
  logic [WAY_W-1:0]  primHitWay, primFreeWay, ovfHitWay, ovfFreeWay;
  logic [PTR_W-1:0]  poolIdx;
  logic [WAY_W-1:0]  primWrWay, ovfWrWay;
  logic [PTR_W-1:0]  ovfWrSet;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign primMatch[w] = primVal[qSet][w]  && (primTag[qSet][w]  == qTag);
    assign ovfMatch[w]  = ovfVal[ovfSel][w] && (ovfTag[ovfSel][w] == qTag);
  end

  // Descending scans leave the lowest-numbered candidate selected
  always_comb begin
    primHitWay  = '0;
    primFreeWay = '0;
    ovfHitWay   = '0;
    ovfFreeWay  = '0;
    poolIdx     = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (primMatch[w])       primHitWay  = WAY_W'(w);
      if (!primVal[qSet][w])  primFreeWay = WAY_W'(w);
      if (ovfMatch[w])        ovfHitWay   = WAY_W'(w);
      if (!ovfVal[ovfSel][w]) ovfFreeWay  = WAY_W'(w);
    end
    for (int p = OSETS - 1; p >= 0; p--) begin
      if (!taken[p]) poolIdx = PTR_W'(p);
    end
  end

  assign primHit   = |primMatch;
  assign primFull  = &primVal[qSet];
  assign primData  = primDat[qSet][primHitWay];
  assign linked    = linkBit[qSet];
  assign linkPtr   = linkPtrArr[qSet];
  assign ovfHit    = |ovfMatch;
  assign ovfFull   = &ovfVal[ovfSel];
  assign ovfData   = ovfDat[ovfSel][ovfHitWay];
  assign poolAvail = ~&taken;

  assign primWrWay = primHit ? primHitWay : primFreeWay;
  assign ovfWrSet  = stb.claim ? poolIdx : ovfSel;
  assign ovfWrWay  = stb.claim ? '0 : (ovfHit ? ovfHitWay : ovfFreeWay);

  // Occupancy, links and pool ownership
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) begin
        primVal[s]    <= '0;
        linkPtrArr[s] <= '0;
      end
      for (int p = 0; p < OSETS; p++) ovfVal[p] <= '0;
      linkBit <= '0;
      taken   <= '0;
    end else begin
      if (stb.wrPrim) primVal[qSet][primWrWay] <= 1'b1;
      if (stb.wrOvf || stb.claim) ovfVal[ovfWrSet][ovfWrWay] <= 1'b1;
      if (stb.claim) begin
        linkBit[qSet]    <= 1'b1;
        linkPtrArr[qSet] <= poolIdx;
        taken[poolIdx]   <= 1'b1;
      end
    end
  end

  // Tags and payloads need no reset; validity guards them
  always_ff @(posedge clk) begin
    if (stb.wrPrim) begin
      primTag[qSet][primWrWay] <= qTag;
      primDat[qSet][primWrWay] <= qData;
    end
    if (stb.wrOvf || stb.claim) begin
      ovfTag[ovfWrSet][ovfWrWay] <= qTag;
      ovfDat[ovfWrSet][ovfWrWay] <= qData;
    end
  end

endmodule

// File: rtl/rso_control.sv
module rso_control
  import replica_store_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int SET_W  = 5,
  parameter int PTR_W  = 4,
  localparam int TAG_W = ADDR_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [DATA_W-1:0] rspData,
  output logic [SET_W-1:0]  qSet,
  output logic [TAG_W-1:0]  qTag,
  output logic [DATA_W-1:0] qData,
  output logic [PTR_W-1:0]  ovfSel,
  output dpStrobe_t         stb,
  input  logic              primHit,
  input  logic              primFull,
  input  logic [DATA_W-1:0] primData,
  input  logic              linked,
  input  logic [PTR_W-1:0]  linkPtr,
  input  logic              ovfHit,
  input  logic              ovfFull,
  input  logic [DATA_W-1:0] ovfData,
  input  logic              poolAvail
);

  typedef enum logic {S_IDLE, S_OVF} state_e;

  state_e            state;
  cmdOp_e            heldOp, curOp;
  logic [SET_W-1:0]  heldSet;
  logic [TAG_W-1:0]  heldTag;
  logic [DATA_W-1:0] heldData;
  logic              inOvf, accept, goOvf, fin;
  rspStatus_e        finStatus;
  logic [DATA_W-1:0] finData;

  assign inOvf    = (state == S_OVF);
  assign cmdReady = !inOvf;
  assign accept   = cmdValid && cmdReady;
  assign curOp    = inOvf ? heldOp : cmdOp_e'(cmdOp);
  assign qSet     = inOvf ? heldSet  : cmdAddr[SET_W-1:0];
  assign qTag     = inOvf ? heldTag  : cmdAddr[ADDR_W-1:SET_W];
  assign qData    = inOvf ? heldData : cmdData;

  always_comb begin
    stb       = '0;
    goOvf     = 1'b0;
    fin       = 1'b0;
    finStatus = ST_OK;
    finData   = '0;
    if (inOvf) begin
      fin = 1'b1;
      unique case (curOp)
        OP_INSERT: begin
          if (ovfHit || !ovfFull) stb.wrOvf = 1'b1;
          else                    finStatus = ST_FULL;
        end
        OP_UPDATE: begin
          if (ovfHit) stb.wrOvf = 1'b1;
          else        finStatus = ST_MISS;
        end
        default: begin
          if (ovfHit) finData   = ovfData;
          else        finStatus = ST_MISS;
        end
      endcase
    end else if (accept) begin
      if (primHit) begin
        fin = 1'b1;
        if (curOp == OP_INSERT || curOp == OP_UPDATE) stb.wrPrim = 1'b1;
        else                                           finData    = primData;
      end else if (linked) begin
        goOvf = 1'b1;
      end else begin
        fin = 1'b1;
        if (curOp == OP_INSERT) begin
          if (!primFull)      stb.wrPrim = 1'b1;
          else if (poolAvail) stb.claim  = 1'b1;
          else                finStatus  = ST_FULL;
        end else begin
          finStatus = ST_MISS;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      heldOp    <= OP_LOOKUP;
      heldSet   <= '0;
      heldTag   <= '0;
      heldData  <= '0;
      ovfSel    <= '0;
      rspValid  <= 1'b0;
      rspStatus <= ST_OK;
      rspData   <= '0;
    end else begin
      rspValid <= fin;
      if (fin) begin
        rspStatus <= finStatus;
        rspData   <= finData;
      end
      if (goOvf) begin
        state    <= S_OVF;
        heldOp   <= curOp;
        heldSet  <= qSet;
        heldTag  <= qTag;
        heldData <= qData;
        ovfSel   <= linkPtr;
      end else if (inOvf) begin
        state <= S_IDLE;
      end
    end
  end

endmodule

// File: rtl/replica_store.sv
module replica_store
  import replica_store_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int SET_BITS = 5,
  parameter int WAYS     = 6,
  parameter int OVF_SETS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              rspValid,
  output logic [1:0]        rspStatus,
  output logic [DATA_W-1:0] rspData
);

  localparam int NSETS = 1 << SET_BITS;
  localparam int TAG_W = ADDR_W - SET_BITS;
  localparam int PTR_W = $clog2(OVF_SETS);

  logic [SET_BITS-1:0] qSet;
  logic [TAG_W-1:0]    qTag;
  logic [DATA_W-1:0]   qData;
  logic [PTR_W-1:0]    ovfSel, linkPtr;
  dpStrobe_t           stb;
  logic                primHit, primFull, linked, ovfHit, ovfFull, poolAvail;
  logic [DATA_W-1:0]   primData, ovfData;

  rso_control #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SET_W(SET_BITS), .PTR_W(PTR_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspData(rspData),
    .qSet(qSet), .qTag(qTag), .qData(qData), .ovfSel(ovfSel), .stb(stb),
    .primHit(primHit), .primFull(primFull), .primData(primData),
    .linked(linked), .linkPtr(linkPtr),
    .ovfHit(ovfHit), .ovfFull(ovfFull), .ovfData(ovfData),
    .poolAvail(poolAvail)
  );

  rso_datapath #(
    .TAG_W(TAG_W), .DATA_W(DATA_W), .NSETS(NSETS), .WAYS(WAYS), .OSETS(OVF_SETS)
  ) u_dp (
    .clk(clk), .rst(rst),
    .qSet(qSet), .qTag(qTag), .qData(qData), .ovfSel(ovfSel), .stb(stb),
    .primHit(primHit), .primFull(primFull), .primData(primData),
    .linked(linked), .linkPtr(linkPtr),
    .ovfHit(ovfHit), .ovfFull(ovfFull), .ovfData(ovfData),
    .poolAvail(poolAvail)
  );

endmodule

// File: rtl/replica_store_checker.sv
module replica_store_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [1:0]        cmdOp,
  input logic              rspValid,
  input logic [1:0]        rspStatus,
  input logic [DATA_W-1:0] rspData
);

  logic [1:0] lastOp;

  always_ff @(posedge clk) begin
    if (rst)                        lastOp <= 2'd0;
    else if (cmdValid && cmdReady)  lastOp <= cmdOp;
  end

  // R1: ready and silent on the first cycle out of reset
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmdReady && !rspValid));

  // R2: every response traces back to an accepted request or a search cycle
  p_rsp_has_cause_r2: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> ($past(cmdValid && cmdReady) || $past(!cmdReady)));

  // R2: only defined status codes appear
  p_status_code_r2: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspStatus != 2'd3));

  // R6: a no-room answer only ever belongs to an insert
  p_full_only_insert_r6: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspStatus == 2'd2) |-> (lastOp == 2'd1));

  // R8: not-found answers carry zero data
  p_miss_zero_data_r8: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspStatus == 2'd1) |-> (rspData == '0));

  // R9: the overflow search cycle is always followed by its answer
  p_wait_ends_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    !cmdReady |=> rspValid);

  // R10: the stall lasts exactly one cycle
  p_wait_single_r10: assert property (@(posedge clk) disable iff (rst)
    !cmdReady |=> cmdReady);

  // R10: no answer is given while stalled
  p_no_rsp_while_wait_r10: assert property (@(posedge clk) disable iff (rst)
    !cmdReady |-> !rspValid);

endmodule

bind replica_store replica_store_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_replica_store.sv
module test_replica_store;

  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 64;
  localparam int SET_BITS = 5;
  localparam int NSETS    = 32;
  localparam int WAYS     = 6;
  localparam int OSETS    = 16;
  localparam int NTAG     = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cmdValid = 1'b0;
  logic              cmdReady;
  logic [1:0]        cmdOp = 2'd0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [DATA_W-1:0] cmdData = '0;
  logic              rspValid;
  logic [1:0]        rspStatus;
  logic [DATA_W-1:0] rspData;

  always #4 clk = ~clk;

  replica_store i_replica_store (
    .clk(clk), .rst(rst),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rspValid(rspValid), .rspStatus(rspStatus), .rspData(rspData)
  );

  int nRun  = 0;
  int nFail = 0;

  // Reference occupancy model built from the requirements
  bit          mPres  [NSETS][NTAG];
  bit          mInOvf [NSETS][NTAG];
  logic [63:0] mData  [NSETS][NTAG];
  int          primCnt [NSETS];
  int          ovfCnt  [NSETS];
  bit          mLinked [NSETS];
  int          poolUsed = 0;

  function automatic logic [63:0] mkData(int s, int t, int v);
    return {32'(s * 1031 + t * 97 + v * 13 + 1),
            32'(32'hC0DE0000 ^ (t << 8) ^ s ^ (v << 20))};
  endfunction

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] op, input int s, input int t,
                       input logic [63:0] d, output logic [1:0] st,
                       output logic [63:0] rd, output int lat, output bit dip);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdAddr  = ADDR_W'((t << SET_BITS) | s);
    cmdData  = d;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 1;
    dip = 1'b0;
    while (!rspValid && lat < 8) begin
      if (!cmdReady) dip = 1'b1;
      @(posedge clk);
      @(negedge clk);
      lat++;
    end
    st = rspStatus;
    rd = rspData;
  endtask

  task automatic mLookup(string req, int s, int t);
    logic [1:0]  st;
    logic [63:0] rd;
    int          lat;
    bit          dip;
    int          eLat;
    eLat = mPres[s][t] ? (mInOvf[s][t] ? 2 : 1) : (mLinked[s] ? 2 : 1);
    doCmd(2'd0, s, t, 64'd0, st, rd, lat, dip);
    check(req, "lookup status", 64'(st), mPres[s][t] ? 64'd0 : 64'd1);
    check(req, "lookup data", rd, mPres[s][t] ? mData[s][t] : 64'd0);
    check(req, "lookup latency", 64'(lat), 64'(eLat));
    check("R10", "ready low during search", 64'(dip), 64'(eLat == 2));
  endtask

  task automatic mInsert(string req, int s, int t, logic [63:0] d);
    logic [1:0]  st;
    logic [63:0] rd;
    int          lat;
    bit          dip;
    int          eLat;
    int          eSt;
    eSt = 0;
    if (mPres[s][t]) begin
      eLat = mInOvf[s][t] ? 2 : 1;
      mData[s][t] = d;
    end else if (mLinked[s]) begin
      eLat = 2;
      if (ovfCnt[s] < WAYS) begin
        ovfCnt[s]++;
        mPres[s][t] = 1'b1; mInOvf[s][t] = 1'b1; mData[s][t] = d;
      end else eSt = 2;
    end else begin
      eLat = 1;
      if (primCnt[s] < WAYS) begin
        primCnt[s]++;
        mPres[s][t] = 1'b1; mInOvf[s][t] = 1'b0; mData[s][t] = d;
      end else if (poolUsed < OSETS) begin
        poolUsed++;
        mLinked[s] = 1'b1; ovfCnt[s] = 1;
        mPres[s][t] = 1'b1; mInOvf[s][t] = 1'b1; mData[s][t] = d;
      end else eSt = 2;
    end
    doCmd(2'd1, s, t, d, st, rd, lat, dip);
    check(req, "insert status", 64'(st), 64'(eSt));
    check(req, "insert latency", 64'(lat), 64'(eLat));
  endtask

  task automatic mUpdate(string req, int s, int t, logic [63:0] d);
    logic [1:0]  st;
    logic [63:0] rd;
    int          lat;
    bit          dip;
    int          eLat;
    bit          hit;
    hit  = mPres[s][t];
    eLat = hit ? (mInOvf[s][t] ? 2 : 1) : (mLinked[s] ? 2 : 1);
    if (hit) mData[s][t] = d;
    doCmd(2'd2, s, t, d, st, rd, lat, dip);
    check(req, "update status", 64'(st), hit ? 64'd0 : 64'd1);
    check(req, "update latency", 64'(lat), 64'(eLat));
  endtask

  // Watchdog: a hung run counts as a failure and still reports
  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", "rspValid after reset", 64'(rspValid), 64'd0);
    check("R1", "cmdReady after reset", 64'(cmdReady), 64'd1);

    // R1: empty store, every set misses
    for (int s = 0; s < NSETS; s++) mLookup("R1", s, 3);

    // R3, R2: six entries stay in the primary set
    for (int t = 1; t <= 6; t++) mInsert("R3", 3, t, mkData(3, t, 0));
    for (int t = 1; t <= 6; t++) mLookup("R2", 3, t);

    // R4: seventh entry claims an overflow set
    mInsert("R4", 3, 7, mkData(3, 7, 0));
    mLookup("R4", 3, 7);

    // R9: miss latency depends on the link
    mLookup("R9", 3, 15);
    mLookup("R9", 4, 15);

    // R7: rewriting an entry consumes no way
    for (int t = 1; t <= 5; t++) mInsert("R7", 5, t, mkData(5, t, 0));
    mInsert("R7", 5, 2, mkData(5, 2, 1));
    mInsert("R7", 5, 2, mkData(5, 2, 2));
    mInsert("R7", 5, 6, mkData(5, 6, 0));
    mLookup("R7", 5, 6);
    mLookup("R7", 5, 2);

    // R8: updates of present and absent addresses
    mUpdate("R8", 3, 7, mkData(3, 7, 5));
    mLookup("R8", 3, 7);
    mUpdate("R8", 3, 1, mkData(3, 1, 5));
    mLookup("R8", 3, 1);
    mUpdate("R8", 3, 14, mkData(3, 14, 5));
    mLookup("R8", 3, 14);
    mUpdate("R8", 9, 2, mkData(9, 2, 5));
    mLookup("R8", 9, 2);

    // R11: fill the linked overflow set, then one more
    for (int t = 8; t <= 13; t++) mInsert("R11", 3, t, mkData(3, t, 0));
    mLookup("R6", 3, 13);
    for (int t = 1; t <= 12; t++) mLookup("R6", 3, t);

    // R5: exhaust the pool with fifteen more sets
    for (int s = 6; s <= 20; s++)
      for (int t = 1; t <= 7; t++) mInsert("R5", s, t, mkData(s, t, 0));
    for (int t = 1; t <= 7; t++) mInsert("R5", 21, t, mkData(21, t, 0));
    mInsert("R5", 5, 7, mkData(5, 7, 0));
    mLookup("R6", 21, 7);
    mLookup("R6", 5, 7);

    // R2, R6: full sweep of the modelled address space
    for (int s = 0; s < NSETS; s++)
      for (int t = 0; t < NTAG; t++) mLookup("R2", s, t);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule